// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block holds the per-vector message table and the pending-bit array of a small endpoint that signals interrupts by memory writes. Each interrupt source drives a level input. A rising level on an unmasked vector makes the block emit one message write, built from that vector's programmed address and data. When the vector is masked, or the function as a whole is masked or disabled, the request is remembered as a pending bit instead.

Software reaches the table and the pending array through a 4 KB window with a 32-bit word port. Each vector owns four consecutive words. The pending bits are read-only and start at offset 0x800. Pending requests are replayed in three cases: when a table write unmasks a pending entry, when the function is enabled or unmasked, and when the rescan input pulses. A replay walks the vectors one per cycle.

Messages leave on a single-beat valid/ready stream with a 64-bit address and 32-bit data. Once `msg_valid` is high, the address and data stay constant until `msg_ready` is seen high at a clock edge. Each such edge transfers exactly one message. No request is dropped while the stream is stalled. Requests that arrive during a stall wait in per-vector service flags and go out after the stall ends, lowest vector first.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset every table word and every pending bit reads as zero and `msg_valid` is low.
- R2: Vector v occupies window offsets 16v..16v+15. The word at +0 is the address low word, +4 the address high word, +8 the message data and +12 the vector control word. Bits [1:0] of `bus_ofs` are ignored and every word reads back what was last written to it.
- R3: A rising `irq_level[v]` on an open function (`fn_enable`=1, `fn_mask`=0) with control bit 0 of vector v clear produces exactly one message. Its address is {high word, low word with bits [1:0] zeroed}, its data is the data word, and the pending bit of v ends up clear.
- R4: A level that stays high or falls produces no message.
- R5: A rising request while control bit 0 of v is set, or `fn_mask`=1, or `fn_enable`=0, sends nothing and sets the pending bit of v. That bit is bit (v mod 32) of the word at offset 0x800 + 4·(v div 32).
- R6: Writes at offsets 0x800 and above change neither the pending bits nor anything else.
- R7: One cycle after a table write, the written entry is checked. If it is pending, unmasked and the function is open, it is sent and its pending bit cleared.
- R8: A pulse on `rescan_req`, a rising `fn_enable` or a falling `fn_mask` starts a walk over vectors 0..N-1. The walk sends each vector that is pending and unmasked while the function is open, and pauses while the stream is stalled.
- R9: While `msg_valid` is high and `msg_ready` is low, the message holds its address and data.
- R10: Reads between the end of the table and 0x800, or past the last pending word, return zero.
- R11: Requests that become ready to send in the same cycle, or during a stall, are all sent, lowest vector first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ofs | input | 12 | Window offset of the 32-bit access |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_level | input | NUM_VEC | Per-vector request levels |
| fn_enable | input | 1 | Function-wide enable |
| fn_mask | input | 1 | Function-wide mask |
| rescan_req | input | 1 | One-cycle pulse to start a pending walk |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Requests are tried against each masking source in turn: the per-vector control bit, the function mask and the disabled function. Each case has a matching release path (table write, unmask, enable, explicit rescan), which shows which path replays a pending vector and which does not. Random table contents and random per-vector masks, mixed with single and simultaneous pulses, separate the address low-bit clearing and the per-entry field selection from neighbouring entries. A held-low ready with two simultaneous requests shows that both the stall hold and the lowest-first ordering work. Reads and writes to unmapped offsets and the pending region show that those accesses have no effect.

// File: rtl/msix_vc_pkg.sv
package msix_vc_pkg;
  localparam int          WIN_W      = 12;
  localparam logic [11:0] PBA_OFS    = 12'h800;
  localparam int          ENT_WORDS  = 4;
  localparam int          ENT_BYTES  = 16;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } ent_word_e;
endpackage

// File: rtl/msix_vt_store.sv
module msix_vt_store
  import msix_vc_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WIN_W-1:0]           acc_ofs,
  input  logic                       wr_en,
  input  logic [31:0]                wr_data,
  output logic [31:0]                rd_data,
  input  logic [NUM_VEC-1:0]         pend,
  output logic [63:0]                ent_addr [NUM_VEC],
  output logic [31:0]                ent_data [NUM_VEC],
  output logic [NUM_VEC-1:0]         ent_mask,
  output logic                       chk_valid,
  output logic [$clog2(NUM_VEC)-1:0] chk_idx
);
  // Table must stay below the pending region: NUM_VEC <= 128.
  localparam int          IDX_W     = $clog2(NUM_VEC);
  localparam int          TBL_WORDS = NUM_VEC * ENT_WORDS;
  localparam int          WIDX_W    = $clog2(TBL_WORDS);
  localparam logic [12:0] TBL_END   = 13'(TBL_WORDS * 4);
  localparam int          PBA_WORDS = (NUM_VEC + 31) / 32;
  localparam logic [12:0] PBA_END   = 13'(int'(PBA_OFS) + PBA_WORDS * 4);

  logic [31:0] words [TBL_WORDS];
  logic        in_tbl, in_pba;
  logic [WIDX_W-1:0] word_idx;
  logic [PBA_WORDS*32-1:0] pend_pad;

  assign in_tbl   = {1'b0, acc_ofs} < TBL_END;
  assign in_pba   = (acc_ofs >= PBA_OFS) && ({1'b0, acc_ofs} < PBA_END);
  assign word_idx = acc_ofs[WIDX_W+1:2];
  assign pend_pad = {{(PBA_WORDS*32-NUM_VEC){1'b0}}, pend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_WORDS; i++) words[i] <= '0;
      chk_valid <= 1'b0;
      chk_idx   <= '0;
    end else begin
      if (wr_en && in_tbl) words[word_idx] <= wr_data;
      chk_valid <= wr_en && in_tbl;
      chk_idx   <= acc_ofs[IDX_W+3:4];
    end
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    assign ent_addr[v] = {words[v*ENT_WORDS + int'(W_ADDR_HI)],
                          words[v*ENT_WORDS + int'(W_ADDR_LO)][31:2], 2'b00};
    assign ent_data[v] = words[v*ENT_WORDS + int'(W_DATA)];
    assign ent_mask[v] = words[v*ENT_WORDS + int'(W_CTRL)][0];
  end

  always_comb begin
    rd_data = '0;
    if (in_tbl) begin
      rd_data = words[word_idx];
    end else if (in_pba) begin
      for (int w = 0; w < PBA_WORDS; w++)
        if (acc_ofs[10:2] == 9'(w)) rd_data = pend_pad[32*w +: 32];
    end
  end

  // R6
  pba_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_ofs >= PBA_OFS) |=> !chk_valid);
endmodule

// File: rtl/msix_vt_scan.sv
module msix_vt_scan #(
  parameter int NUM_VEC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       stall,
  output logic                       scan_go,
  output logic [$clog2(NUM_VEC)-1:0] scan_idx
);
  localparam int                   IDX_W = $clog2(NUM_VEC);
  localparam logic [IDX_W-1:0]     LAST  = IDX_W'(NUM_VEC - 1);

  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      scan_idx <= '0;
    end else if (start) begin
      active   <= 1'b1;
      scan_idx <= '0;
    end else if (active && !stall) begin
      if (scan_idx == LAST) active <= 1'b0;
      scan_idx <= scan_idx + 1'b1;
    end
  end

  assign scan_go = active && !stall;

  // R8
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stall && !start) |=> (active && $stable(scan_idx)));
endmodule

// File: rtl/msix_vt_dispatch.sv
module msix_vt_dispatch #(
  parameter int NUM_VEC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_VEC-1:0]         irq_level,
  input  logic                       open,
  input  logic [NUM_VEC-1:0]         ent_mask,
  input  logic [63:0]                ent_addr [NUM_VEC],
  input  logic [31:0]                ent_data [NUM_VEC],
  input  logic                       chk_valid,
  input  logic [$clog2(NUM_VEC)-1:0] chk_idx,
  input  logic                       scan_go,
  input  logic [$clog2(NUM_VEC)-1:0] scan_idx,
  output logic [NUM_VEC-1:0]         pend,
  output logic                       stall,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [63:0]                msg_addr,
  output logic [31:0]                msg_data
);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] irq_q, rise, fire_q, set_fire, set_pend, pick_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic               any_fire, slot_free;

  assign rise      = irq_level & ~irq_q;
  assign slot_free = !msg_valid || msg_ready;
  assign stall     = !slot_free;
  assign any_fire  = |fire_q;

  always_comb begin
    set_fire = '0;
    set_pend = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (rise[v]) begin
        if (!open || ent_mask[v]) set_pend[v] = 1'b1;
        else                      set_fire[v] = 1'b1;
      end
    end
    if (chk_valid && pend[chk_idx] && !ent_mask[chk_idx] && open)
      set_fire[chk_idx] = 1'b1;
    if (scan_go && pend[scan_idx] && !ent_mask[scan_idx] && open)
      set_fire[scan_idx] = 1'b1;
  end

  always_comb begin
    pick_idx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (fire_q[v]) pick_idx = IDX_W'(v);
    pick_oh = '0;
    if (slot_free && any_fire) pick_oh[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      fire_q    <= '0;
      pend      <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_q  <= irq_level;
      fire_q <= (fire_q & ~pick_oh) | set_fire;
      pend   <= (pend & ~pick_oh) | set_pend;
      if (slot_free) begin
        msg_valid <= any_fire;
        if (any_fire) begin
          msg_addr <= ent_addr[pick_idx];
          msg_data <= ent_data[pick_idx];
        end
      end
    end
  end

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R3
  msg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(any_fire));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    // R5
    masked_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[v] && (!open || ent_mask[v])) |=> pend[v]);
  end
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_ofs,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_VEC-1:0] irq_level,
  input  logic               fn_enable,
  input  logic               fn_mask,
  input  logic               rescan_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic [63:0]        ent_addr [NUM_VEC];
  logic [31:0]        ent_data [NUM_VEC];
  logic [NUM_VEC-1:0] ent_mask, pend;
  logic               chk_valid, scan_go, stall, open, start;
  logic [IDX_W-1:0]   chk_idx, scan_idx;
  logic               en_q, mask_q;

  assign open  = fn_enable && !fn_mask;
  assign start = rescan_req || (fn_enable && !en_q) || (!fn_mask && mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      en_q   <= fn_enable;
      mask_q <= fn_mask;
    end
  end

  msix_vt_store #(.NUM_VEC(NUM_VEC)) u_store (
    .clk(clk), .rst_n(rst_n), .acc_ofs(bus_ofs), .wr_en(bus_wr),
    .wr_data(bus_wdata), .rd_data(bus_rdata), .pend(pend),
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_mask(ent_mask),
    .chk_valid(chk_valid), .chk_idx(chk_idx)
  );

  msix_vt_scan #(.NUM_VEC(NUM_VEC)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
    .scan_go(scan_go), .scan_idx(scan_idx)
  );

  msix_vt_dispatch #(.NUM_VEC(NUM_VEC)) u_disp (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .open(open),
    .ent_mask(ent_mask), .ent_addr(ent_addr), .ent_data(ent_data),
    .chk_valid(chk_valid), .chk_idx(chk_idx), .scan_go(scan_go),
    .scan_idx(scan_idx), .pend(pend), .stall(stall),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: tb/msix_vector_ctrl_bench.sv
`timescale 1ns/1ps
module msix_vector_ctrl_bench;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_ofs = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NV-1:0] irq_level = '0;
  logic          fn_enable = 1'b1;
  logic          fn_mask = 1'b0;
  logic          rescan_req = 1'b0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  always #10 clk = ~clk;

  msix_vector_ctrl #(.NUM_VEC(NV)) u_msix_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_level(irq_level),
    .fn_enable(fn_enable), .fn_mask(fn_mask), .rescan_req(rescan_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_lo [NV], m_hi [NV], m_dat [NV], m_ctl [NV];
  logic [NV-1:0] m_pend = '0;
  logic [63:0] exp_a [$], got_a [$];
  logic [31:0] exp_d [$], got_d [$];

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready) begin
      got_a.push_back(msg_addr);
      got_d.push_back(msg_data);
    end

  function automatic logic [63:0] f_addr(int v);
    return {m_hi[v], m_lo[v][31:2], 2'b00};
  endfunction

  function automatic bit f_open();
    return fn_enable && !fn_mask;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_send(int v);
    exp_a.push_back(f_addr(v));
    exp_d.push_back(m_dat[v]);
    m_pend[v] = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bwr(logic [11:0] o, logic [31:0] d);
    @(posedge clk); #2;
    bus_ofs = o; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic brd(logic [11:0] o, output logic [31:0] d);
    @(posedge clk); #2;
    bus_ofs = o;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Table write through the model; R7 replay of the written entry
  task automatic tbl_wr(int v, int k, logic [31:0] val);
    case (k)
      0: m_lo[v] = val;
      1: m_hi[v] = val;
      2: m_dat[v] = val;
      default: m_ctl[v] = val;
    endcase
    bwr(12'(v*16 + k*4), val);
    if (m_pend[v] && !m_ctl[v][0] && f_open()) expect_send(v);
  endtask

  task automatic pulse(logic [NV-1:0] bits);
    for (int v = 0; v < NV; v++)
      if (bits[v]) begin
        if (f_open() && !m_ctl[v][0]) expect_send(v);
        else m_pend[v] = 1'b1;
      end
    @(posedge clk); #2; irq_level = bits;
    tick(2);
    irq_level = '0;
    tick(2);
  endtask

  task automatic sync(string tag);
    logic [31:0] pw;
    tick(14);
    check({tag, " message count"}, 64'(got_a.size()), 64'(exp_a.size()));
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      check({tag, " message address"}, got_a[i], exp_a[i]);
      check({tag, " message data"}, 64'(got_d[i]), 64'(exp_d[i]));
    end
    got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
    brd(12'h800, pw);
    check({tag, " pending word"}, 64'(pw), 64'(m_pend));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    for (int v = 0; v < NV; v++) begin
      m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0; m_ctl[v] = '0;
    end
    tick(4);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    brd(12'h000, d); check("R1 table word 0", 64'(d), 0);
    brd(12'h07C, d); check("R1 last control word", 64'(d), 0);
    brd(12'h800, d); check("R1 pending word", 64'(d), 0);
    check("R1 msg_valid", 64'(msg_valid), 0);

    // R2 program entries, read back, low offset bits ignored
    for (int v = 0; v < NV; v++) begin
      tbl_wr(v, 0, $urandom() | 32'h3);
      tbl_wr(v, 1, $urandom());
      tbl_wr(v, 2, $urandom());
      tbl_wr(v, 3, 32'h0);
    end
    for (int v = 0; v < NV; v++) begin
      brd(12'(v*16), d);     check("R2 address low", 64'(d), 64'(m_lo[v]));
      brd(12'(v*16 + 7), d); check("R2 address high (offset bits 1:0 set)", 64'(d), 64'(m_hi[v]));
      brd(12'(v*16 + 8), d); check("R2 data", 64'(d), 64'(m_dat[v]));
    end
    sync("R2");

    // R3 single unmasked request
    pulse(8'h08);
    sync("R3");

    // R4 held level and falling edge give nothing
    @(posedge clk); #2; irq_level = 8'h10; expect_send(4);
    tick(10);
    irq_level = 8'h00;
    sync("R4");

    // R5 vector-masked request goes pending
    tbl_wr(5, 3, 32'h1);
    pulse(8'h20);
    sync("R5");

    // R6 writes to the pending region are ignored
    bwr(12'h800, 32'h0);
    bwr(12'hFFC, 32'hFFFF_FFFF);
    brd(12'h800, d); check("R6 pending survives write", 64'(d), 64'h20);

    // R7 unmasking write replays the pending vector
    tbl_wr(5, 3, 32'h0);
    sync("R7");

    // R8 function mask release replays pending vectors in order
    @(posedge clk); #2; fn_mask = 1'b1;
    pulse(8'h06);
    sync("R8 masked");
    @(posedge clk); #2; fn_mask = 1'b0;
    expect_send(1); expect_send(2);
    sync("R8 unmask");

    // R8 disabled function: rescan does nothing until enable rises
    @(posedge clk); #2; fn_enable = 1'b0;
    pulse(8'h10);
    @(posedge clk); #2; rescan_req = 1'b1;
    @(posedge clk); #2; rescan_req = 1'b0;
    sync("R8 disabled rescan");
    @(posedge clk); #2; fn_enable = 1'b1;
    expect_send(4);
    sync("R8 enable");

    // R8 explicit rescan with a masked pending vector sends nothing
    tbl_wr(7, 3, 32'h1);
    pulse(8'h80);
    @(posedge clk); #2; rescan_req = 1'b1;
    @(posedge clk); #2; rescan_req = 1'b0;
    sync("R8 masked rescan");
    tbl_wr(7, 3, 32'h0);
    sync("R8 clear");

    // R9 / R11 back-pressure with simultaneous requests
    @(posedge clk); #2; msg_ready = 1'b0;
    pulse(8'h41);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 valid held", 64'(msg_valid), 1);
      check("R9 address held (R11 lowest first)", msg_addr, f_addr(0));
    end
    @(posedge clk); #2; msg_ready = 1'b1;
    sync("R11");

    // R10 unmapped reads
    brd(12'h080, d); check("R10 past table", 64'(d), 0);
    brd(12'h7FC, d); check("R10 below pending", 64'(d), 0);
    brd(12'h804, d); check("R10 past pending", 64'(d), 0);

    // Random mix over R3 R5 R7
    for (int it = 0; it < 40; it++) begin
      int v;
      v = int'($urandom() % NV);
      tbl_wr(v, 3, 32'($urandom() % 2));
      if ($urandom() % 3 == 0) tbl_wr(v, 2, $urandom());
      if ($urandom() % 4 == 0) tbl_wr(v, 0, $urandom());
      pulse(NV'(1) << v);
      sync("R3 R5 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule